// File: doc/BRIEF.md
# Four-Way Victim Cast-Out Controller

This controller handles replacement and write-back for a single set of a four-way set-associative data cache. It tracks the complete recency order of the four ways. On a miss it selects the least-recently-used way as the victim. A modified victim is written back to memory before the refill is requested. A clean or invalid victim goes straight to the refill request.

A snoop from another bus master that lands on a modified line forces that line out to memory. The push carries a normal or a high-priority tag. A push may also be slipped into a refill that has not yet been granted; the refill then waits and resumes afterwards. Tag matching, the data arrays and the bus protocol belong to neighbouring blocks. Toward the bus interface the controller drives a write-back request with a beat counter and a refill request with grant and completion inputs. The per-way valid and modified bits and the current LRU way are brought out for the surrounding cache.

Controller states are `ST_IDLE`, `ST_CASTOUT`, `ST_FILL_REQ`, `ST_FILL_WAIT` and `ST_PUSH`. The transitions are:

- IDLE→PUSH when a snoop hits a modified line.
- IDLE→CASTOUT when a miss picks a modified victim.
- IDLE→FILL_REQ when a miss picks a clean or invalid victim.
- CASTOUT→FILL_REQ on the last acknowledged beat.
- FILL_REQ→PUSH when a snoop hits a modified line.
- FILL_REQ→FILL_WAIT on `fill_gnt`.
- FILL_WAIT→IDLE on `fill_done`.
- PUSH→IDLE or PUSH→FILL_REQ (whichever state the push was entered from) on the last acknowledged beat.

Top module: `castout_ctrl`

## Requirements
- R1: After reset, all ways are invalid and clean, `lru_way` is 0, `wb_req` and `fill_req` are low, and `miss_ready` and `snoop_ready` are high.
- R2: Recency is held as six pairwise bits, one per pair of ways (i,j) with i<j. A bit value of 1 means way i is more recent than way j. The pair order is (0,1),(0,2),(0,3),(1,2),(1,3),(2,3). A hit on a valid way, or a completed fill, makes that way the most recent. `lru_way` names the way older than all three others.
- R3: A miss accepted while the victim is clean or invalid raises `fill_req` on the next cycle, with no write-back request.
- R4: A miss whose victim is valid and modified first raises `wb_req` with `wb_push`=0 and `wb_way` equal to the victim. `fill_req` rises only after the last write-back beat is acknowledged.
- R5: `fill_req` stays high until `fill_gnt`. The controller then waits for `fill_done`. That completion marks the victim valid, marks it modified exactly when the miss was a store, and returns to idle.
- R6: Every write-back moves four 8-byte beats in linear order. `wb_beat` starts at 0 and advances by one on each `wb_beat_ack`.
- R7: When a write-back finishes, the written way's modified bit is clear. A push whose snoop asked for invalidation also clears the valid bit.
- R8: An accepted snoop on a valid modified way starts a push (`wb_push`=1, `wb_hipri` equal to the snoop's priority, `wb_nested`=0 from idle). A snoop on a clean way makes no request, and invalidates that way if asked.
- R9: A push-causing snoop in FILL_REQ drops `fill_req` in the same cycle. It runs the push with `wb_nested`=1 and then returns to FILL_REQ.
- R10: When a miss and a snoop arrive together in idle, the snoop is served first, `miss_ready` is low in that cycle, and the held miss is taken once the push ends.
- R11: A hit on an invalid way changes neither the LRU order nor the modified bits. A writing hit on a valid way sets its modified bit.
- R12: `snoop_ready` is low in CASTOUT, FILL_WAIT and PUSH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Access hit this set this cycle |
| hit_way | input | 2 | Way that hit |
| hit_write | input | 1 | The hitting access is a store |
| miss_valid | input | 1 | Miss waiting for a victim |
| miss_store | input | 1 | The miss is a store |
| miss_ready | output | 1 | Miss accepted this cycle when valid |
| snoop_valid | input | 1 | Snoop matched a line of this set |
| snoop_way | input | 2 | Way the snoop matched |
| snoop_hipri | input | 1 | Snoop asks for a high-priority push |
| snoop_inval | input | 1 | Snoop asks for invalidation |
| snoop_ready | output | 1 | Snoop accepted this cycle when valid |
| wb_req | output | 1 | Write-back request |
| wb_push | output | 1 | Write-back is a snoop push (0: cast-out) |
| wb_hipri | output | 1 | Push is high priority |
| wb_nested | output | 1 | Push is nested inside a pending refill |
| wb_way | output | 2 | Way being written back |
| wb_beat | output | 2 | Index of the current beat |
| wb_beat_ack | input | 1 | Bus took the current beat |
| fill_req | output | 1 | Refill request |
| fill_way | output | 2 | Way being refilled |
| fill_gnt | input | 1 | Refill request accepted |
| fill_done | input | 1 | Refill data written |
| lru_way | output | 2 | Current least-recently-used way |
| line_valid | output | 4 | Valid bit per way |
| line_dirty | output | 4 | Modified bit per way |

## Verification
Two pairs of functions can collide.

The first pair is a snoop and a miss in the idle cycle. The bench raises both in one cycle and confirms that `miss_ready` is low. It checks that a push starts and that the held miss is taken as a refill once the push is acknowledged.

The second pair is a snoop and a refill that is still waiting for its grant. The bench snoops a line while the refill request is up. It judges the result by the refill request dropping in that cycle, a push flagged as nested, and the refill request returning afterwards with the refill still correct.

// File: rtl/castout_pkg.sv
package castout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CASTOUT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_PUSH
    } cast_state_e;

    // Position of the ordering bit for ways (i,j), i<j, among all pairs
    function automatic int pair_index(input int i, input int j, input int ways);
        return i * ways - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/cast_lru.sv
module cast_lru
    import castout_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     a_en,
    input  logic [$clog2(WAYS)-1:0]  a_way,
    input  logic                     b_en,
    input  logic [$clog2(WAYS)-1:0]  b_way,
    output logic [$clog2(WAYS)-1:0]  lru_way
);
    localparam int WW    = $clog2(WAYS);
    localparam int PAIRS = WAYS * (WAYS - 1) / 2;

    logic [PAIRS-1:0] order_q;
    logic [PAIRS-1:0] order_mid;
    logic [PAIRS-1:0] order_nxt;

    function automatic logic [PAIRS-1:0] touch(input logic [PAIRS-1:0] ord,
                                               input logic [WW-1:0]    way);
        logic [PAIRS-1:0] res;
        res = ord;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (WW'(i) == way) res[pair_index(i, j, WAYS)] = 1'b1;
                if (WW'(j) == way) res[pair_index(i, j, WAYS)] = 1'b0;
            end
        end
        return res;
    endfunction

    // Fill first, then hit: a same-cycle hit ends up most recent
    always_comb begin
        order_mid = a_en ? touch(order_q, a_way) : order_q;
        order_nxt = b_en ? touch(order_mid, b_way) : order_mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= '0;
        else        order_q <= order_nxt;
    end

    always_comb begin
        logic oldest;
        lru_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            oldest = 1'b1;
            for (int i = 0; i < WAYS; i++) begin
                for (int j = i + 1; j < WAYS; j++) begin
                    if (i == w && order_q[pair_index(i, j, WAYS)])  oldest = 1'b0;
                    if (j == w && !order_q[pair_index(i, j, WAYS)]) oldest = 1'b0;
                end
            end
            if (oldest) lru_way = WW'(w);
        end
    end

    AST_TOUCH_LEAVES_LRU_A: assert property (@(posedge clk) disable iff (!rst_n)
        a_en && !b_en |=> lru_way != $past(a_way)); // R2
    AST_TOUCH_LEAVES_LRU_B: assert property (@(posedge clk) disable iff (!rst_n)
        b_en |=> lru_way != $past(b_way)); // R2

endmodule

// File: rtl/cast_lines.sv
module cast_lines #(
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_en,
    input  logic [$clog2(WAYS)-1:0]  fill_way,
    input  logic                     fill_dirty,
    input  logic                     clean_en,
    input  logic [$clog2(WAYS)-1:0]  clean_way,
    input  logic                     clean_inval,
    input  logic                     sinv_en,
    input  logic [$clog2(WAYS)-1:0]  sinv_way,
    input  logic                     hit_en,
    input  logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic                     hit_wr,
    output logic [WAYS-1:0]          valid,
    output logic [WAYS-1:0]          dirty
);
    logic [WAYS-1:0] valid_nxt;
    logic [WAYS-1:0] dirty_nxt;

    always_comb begin
        valid_nxt = valid;
        dirty_nxt = dirty;
        if (fill_en) begin
            valid_nxt[fill_way] = 1'b1;
            dirty_nxt[fill_way] = fill_dirty;
        end
        if (clean_en) begin
            dirty_nxt[clean_way] = 1'b0;
            if (clean_inval) valid_nxt[clean_way] = 1'b0;
        end
        if (sinv_en) valid_nxt[sinv_way] = 1'b0;
        // A store hit on a live line wins over any clearing in the same cycle
        if (hit_en && hit_wr && valid[hit_way]) dirty_nxt[hit_way] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            dirty <= '0;
        end else begin
            valid <= valid_nxt;
            dirty <= dirty_nxt;
        end
    end

    AST_CLEAN_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        clean_en && !(hit_en && hit_wr && hit_way == clean_way) && !(fill_en && fill_way == clean_way)
        |=> !dirty[$past(clean_way)]); // R7
    AST_DEAD_HIT_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en && !valid[hit_way] && !dirty[hit_way] && !(fill_en && fill_way == hit_way)
        |=> !dirty[$past(hit_way)]); // R11

endmodule

// File: rtl/cast_beats.sv
module cast_beats #(
    parameter int BEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       ack,
    output logic [$clog2(BEATS)-1:0]   beat,
    output logic                       last
);
    localparam int BW = $clog2(BEATS);

    assign last = active && ack && (beat == BW'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)               beat <= '0;
        else if (!active || last) beat <= '0;
        else if (ack)             beat <= beat + 1'b1;
    end

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        active && ack && !last |=> beat == $past(beat) + 1'b1); // R6
    AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> beat == '0); // R6

endmodule

// File: rtl/castout_ctrl.sv
module castout_ctrl
    import castout_pkg::*;
#(
    parameter int WAYS        = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int BEAT_BYTES  = 8,
    localparam int WW         = $clog2(WAYS),
    localparam int BEATS      = BLOCK_BYTES / BEAT_BYTES,
    localparam int BW         = $clog2(BEATS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_valid,
    input  logic [WW-1:0]   hit_way,
    input  logic            hit_write,
    input  logic            miss_valid,
    input  logic            miss_store,
    output logic            miss_ready,
    input  logic            snoop_valid,
    input  logic [WW-1:0]   snoop_way,
    input  logic            snoop_hipri,
    input  logic            snoop_inval,
    output logic            snoop_ready,
    output logic            wb_req,
    output logic            wb_push,
    output logic            wb_hipri,
    output logic            wb_nested,
    output logic [WW-1:0]   wb_way,
    output logic [BW-1:0]   wb_beat,
    input  logic            wb_beat_ack,
    output logic            fill_req,
    output logic [WW-1:0]   fill_way,
    input  logic            fill_gnt,
    input  logic            fill_done,
    output logic [WW-1:0]   lru_way,
    output logic [WAYS-1:0] line_valid,
    output logic [WAYS-1:0] line_dirty
);
    cast_state_e state_q, state_nxt, ret_q;
    logic [WW-1:0] victim_q, push_way_q;
    logic          store_q, push_hi_q, push_inv_q;

    logic snoop_take, snoop_dirty, push_take, miss_take, victim_dirty;
    logic wb_active, wb_last, fill_en, hit_live;
    logic [WW-1:0] clean_way;

    // ---------------- handshake decode ----------------
    assign snoop_ready  = (state_q == ST_IDLE) || (state_q == ST_FILL_REQ);
    assign snoop_take   = snoop_valid && snoop_ready;
    assign snoop_dirty  = line_valid[snoop_way] && line_dirty[snoop_way];
    assign push_take    = snoop_take && snoop_dirty;
    assign miss_ready   = (state_q == ST_IDLE) && !snoop_take;
    assign miss_take    = miss_valid && miss_ready;
    assign victim_dirty = line_valid[lru_way] && line_dirty[lru_way];
    assign wb_active    = (state_q == ST_CASTOUT) || (state_q == ST_PUSH);
    assign fill_en      = (state_q == ST_FILL_WAIT) && fill_done;
    assign hit_live     = hit_valid && line_valid[hit_way];
    assign clean_way    = (state_q == ST_PUSH) ? push_way_q : victim_q;

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push_take)      state_nxt = ST_PUSH;
                else if (miss_take) state_nxt = victim_dirty ? ST_CASTOUT : ST_FILL_REQ;
            end
            ST_CASTOUT:   if (wb_last) state_nxt = ST_FILL_REQ;
            ST_FILL_REQ: begin
                if (push_take)     state_nxt = ST_PUSH;
                else if (fill_gnt) state_nxt = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: if (fill_done) state_nxt = ST_IDLE;
            ST_PUSH:      if (wb_last) state_nxt = ret_q;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // ---------------- state register and context ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ret_q      <= ST_IDLE;
            victim_q   <= '0;
            store_q    <= 1'b0;
            push_way_q <= '0;
            push_hi_q  <= 1'b0;
            push_inv_q <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (push_take) begin
                ret_q      <= state_q;
                push_way_q <= snoop_way;
                push_hi_q  <= snoop_hipri;
                push_inv_q <= snoop_inval;
            end
            if (miss_take) begin
                victim_q <= lru_way;
                store_q  <= miss_store;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        wb_req    = wb_active;
        wb_push   = (state_q == ST_PUSH);
        wb_hipri  = (state_q == ST_PUSH) && push_hi_q;
        wb_nested = (state_q == ST_PUSH) && (ret_q == ST_FILL_REQ);
        wb_way    = clean_way;
        fill_req  = (state_q == ST_FILL_REQ) && !push_take;
        fill_way  = victim_q;
    end

    // ---------------- datapath pieces ----------------
    cast_beats #(.BEATS(BEATS)) u_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (wb_active),
        .ack    (wb_beat_ack),
        .beat   (wb_beat),
        .last   (wb_last)
    );

    cast_lines #(.WAYS(WAYS)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_en     (fill_en),
        .fill_way    (victim_q),
        .fill_dirty  (store_q),
        .clean_en    (wb_last),
        .clean_way   (clean_way),
        .clean_inval ((state_q == ST_PUSH) && push_inv_q),
        .sinv_en     (snoop_take && !snoop_dirty && snoop_inval),
        .sinv_way    (snoop_way),
        .hit_en      (hit_valid),
        .hit_way     (hit_way),
        .hit_wr      (hit_write),
        .valid       (line_valid),
        .dirty       (line_dirty)
    );

    cast_lru #(.WAYS(WAYS)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (fill_en),
        .a_way   (victim_q),
        .b_en    (hit_live),
        .b_way   (hit_way),
        .lru_way (lru_way)
    );

    // ---------------- assertions ----------------
    AST_WB_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && fill_req)); // R9
    AST_CASTOUT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_push && wb_beat_ack && wb_beat == BW'(BEATS - 1)
        |=> state_q == ST_FILL_REQ); // R4
    AST_CLEAN_VICTIM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        miss_take && !victim_dirty |=> state_q == ST_FILL_REQ && !wb_req); // R3
    AST_NESTED_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_nested && wb_beat_ack && wb_beat == BW'(BEATS - 1) |=> state_q == ST_FILL_REQ); // R9
    AST_SNOOP_BEFORE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && push_take && state_q == ST_IDLE |=> wb_push && !wb_nested); // R10
    AST_NO_SNOOP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !snoop_ready); // R12

endmodule

// File: tb/tb_castout_ctrl.sv
module tb_castout_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_valid = 0, hit_write = 0;
    logic [1:0] hit_way = '0;
    logic       miss_valid = 0, miss_store = 0;
    logic       miss_ready;
    logic       snoop_valid = 0, snoop_hipri = 0, snoop_inval = 0;
    logic [1:0] snoop_way = '0;
    logic       snoop_ready;
    logic       wb_req, wb_push, wb_hipri, wb_nested;
    logic [1:0] wb_way, wb_beat;
    logic       wb_beat_ack = 0;
    logic       fill_req;
    logic [1:0] fill_way;
    logic       fill_gnt = 0, fill_done = 0;
    logic [1:0] lru_way;
    logic [3:0] line_valid, line_dirty;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    castout_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .hit_valid(hit_valid), .hit_way(hit_way), .hit_write(hit_write),
        .miss_valid(miss_valid), .miss_store(miss_store), .miss_ready(miss_ready),
        .snoop_valid(snoop_valid), .snoop_way(snoop_way), .snoop_hipri(snoop_hipri),
        .snoop_inval(snoop_inval), .snoop_ready(snoop_ready),
        .wb_req(wb_req), .wb_push(wb_push), .wb_hipri(wb_hipri), .wb_nested(wb_nested),
        .wb_way(wb_way), .wb_beat(wb_beat), .wb_beat_ack(wb_beat_ack),
        .fill_req(fill_req), .fill_way(fill_way), .fill_gnt(fill_gnt), .fill_done(fill_done),
        .lru_way(lru_way), .line_valid(line_valid), .line_dirty(line_dirty)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Runs four beats of a write-back and checks the request fields on each
    task automatic run_wb(input string req, input int way, input int push,
                          input int hi, input int nested);
        for (int b = 0; b < 4; b++) begin
            check(req, "wb_req", wb_req, 1);
            check("R6", "wb_beat", wb_beat, b);
            check(req, "wb_way", wb_way, way);
            check(req, "wb_push", wb_push, push);
            check(req, "wb_hipri", wb_hipri, hi);
            check(req, "wb_nested", wb_nested, nested);
            check("R9", "fill_req low during write-back", fill_req, 0);
            check("R12", "snoop_ready low during write-back", snoop_ready, 0);
            wb_beat_ack = 1;
            tick();
            wb_beat_ack = 0;
        end
        check(req, "wb_req after last beat", wb_req, 0);
    endtask

    // Grant and complete a pending refill
    task automatic finish_fill(input int way, input int store);
        check("R5", "fill_req", fill_req, 1);
        check("R5", "fill_way", fill_way, way);
        fill_gnt = 1;
        tick();
        fill_gnt = 0;
        check("R5", "fill_req after grant", fill_req, 0);
        check("R12", "snoop_ready in fill wait", snoop_ready, 0);
        fill_done = 1;
        tick();
        fill_done = 0;
        check("R5", "valid after fill", line_valid[way], 1);
        check("R5", "dirty after fill", line_dirty[way], store);
        check("R5", "miss_ready after fill", miss_ready, 1);
    endtask

    task automatic clean_miss(input int exp_way, input int store);
        miss_valid = 1;
        miss_store = store;
        #1;
        check("R3", "miss_ready", miss_ready, 1);
        tick();
        miss_valid = 0;
        check("R3", "no write-back for clean victim", wb_req, 0);
        finish_fill(exp_way, store);
    endtask

    task automatic hit(input int way, input int wr);
        hit_valid = 1;
        hit_way   = 2'(way);
        hit_write = wr;
        tick();
        hit_valid = 0;
        hit_write = 0;
    endtask

    task automatic t_reset();
        check("R1", "lru_way", lru_way, 0);
        check("R1", "line_valid", line_valid, 0);
        check("R1", "line_dirty", line_dirty, 0);
        check("R1", "wb_req", wb_req, 0);
        check("R1", "fill_req", fill_req, 0);
        check("R1", "miss_ready", miss_ready, 1);
        check("R1", "snoop_ready", snoop_ready, 1);
    endtask

    task automatic t_fill_all();
        clean_miss(0, 0); check("R2", "lru after fill 0", lru_way, 1);
        clean_miss(1, 0); check("R2", "lru after fill 1", lru_way, 2);
        clean_miss(2, 0); check("R2", "lru after fill 2", lru_way, 3);
        clean_miss(3, 1); check("R2", "lru after fill 3", lru_way, 0);
    endtask

    task automatic t_hits();
        hit(0, 0); check("R2", "lru after hit 0", lru_way, 1);
        hit(1, 1); check("R11", "store hit sets dirty 1", line_dirty[1], 1);
        check("R2", "lru after hit 1", lru_way, 2);
        hit(2, 1); check("R11", "store hit sets dirty 2", line_dirty[2], 1);
        check("R2", "lru after hit 2", lru_way, 3);
    endtask

    task automatic t_castout();
        miss_valid = 1;
        miss_store = 0;
        tick();
        miss_valid = 0;
        check("R4", "fill_req held back", fill_req, 0);
        run_wb("R4", 3, 0, 0, 0);
        check("R7", "victim dirty cleared", line_dirty[3], 0);
        check("R4", "refill after cast-out", fill_req, 1);
        finish_fill(3, 0);
        check("R2", "lru after refill 3", lru_way, 0);
    endtask

    task automatic t_snoop_idle();
        snoop_valid = 1; snoop_way = 2'd1; snoop_hipri = 0; snoop_inval = 0;
        tick();
        snoop_valid = 0;
        check("R8", "miss_ready during push", miss_ready, 0);
        run_wb("R8", 1, 1, 0, 0);
        check("R7", "push cleans way 1", line_dirty[1], 0);
        check("R7", "push keeps way 1 valid", line_valid[1], 1);
        // Clean line, invalidating snoop
        snoop_valid = 1; snoop_way = 2'd0; snoop_inval = 1;
        #1;
        check("R8", "no request for clean snoop", wb_req, 0);
        tick();
        snoop_valid = 0; snoop_inval = 0;
        check("R8", "clean snoop no push", wb_req, 0);
        check("R8", "clean snoop invalidates", line_valid[0], 0);
        // Hit on the now invalid way 0
        hit(0, 1);
        check("R11", "dead hit leaves dirty", line_dirty[0], 0);
        check("R11", "dead hit leaves lru", lru_way, 0);
    endtask

    task automatic t_collide_and_nest();
        miss_valid = 1; miss_store = 1;
        snoop_valid = 1; snoop_way = 2'd2; snoop_hipri = 1; snoop_inval = 1;
        #1;
        check("R10", "miss_ready low beside snoop", miss_ready, 0);
        tick();
        snoop_valid = 0; snoop_hipri = 0; snoop_inval = 0;
        run_wb("R10", 2, 1, 1, 0);
        check("R7", "invalidating push clears valid", line_valid[2], 0);
        check("R7", "invalidating push clears dirty", line_dirty[2], 0);
        check("R10", "held miss now accepted", miss_ready, 1);
        tick();
        miss_valid = 0;
        check("R10", "refill for held miss", fill_req, 1);
        check("R10", "victim way 0", fill_way, 0);
        // Make way 3 modified while the refill waits
        hit(3, 1);
        check("R11", "dirty 3 in fill_req", line_dirty[3], 1);
        snoop_valid = 1; snoop_way = 2'd3;
        #1;
        check("R9", "fill_req drops for push", fill_req, 0);
        check("R12", "snoop_ready in fill_req", snoop_ready, 1);
        tick();
        snoop_valid = 0;
        run_wb("R9", 3, 1, 0, 1);
        check("R9", "back to refill", fill_req, 1);
        finish_fill(0, 1);
        check("R2", "lru after nested refill", lru_way, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_fill_all();
        t_hits();
        t_castout();
        t_snoop_idle();
        t_collide_and_nest();
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule